// File: doc/BRIEF.md
# Byte-Lane Word Bridge

This block lives on a peripheral card and rebuilds a 16-bit device data path from a host bus that only carries 8 data bits. The host moves every word as two byte cycles in a fixed order. The less significant byte comes first and is flagged by the low address line being high. The more significant byte follows with that line low. The bridge watches four host controls: card select, the low address line, the read strobe and the active-low write pulse.

On a write, the bridge keeps the first byte in a holding register. When the second byte arrives, it presents the full word to the device together with a single write strobe. On a read, it routes the requested half of the device word onto the 8-bit bus and raises a drive enable. That enable stands in for the bus buffers, which are high-impedance whenever the card is not selected.

The host numbers its data pins with bit 0 as the most significant bit. The device side numbers bit 15 as the most significant bit. Every byte lane is therefore bit-reversed as it passes through the bridge.

Top module: `bmx_bridge`

## Requirements
- R1: While the synchronous active-low reset is low at a clock edge, the holding register is cleared. An even write made right after reset therefore presents 0x00 on `dev_wdata[7:0]`.
- R2: A clock edge with card selected, `host_a_lo`=1, `host_rd`=0 and `host_we_n`=0 (an odd write) loads the holding register with the host byte. The register stores that byte as a device-numbered value, so host pin k lands at device bit 7-k.
- R3: During an even write (card selected, `host_a_lo`=0, `host_rd`=0, `host_we_n`=0), `dev_wdata[15:8]` equals the live host byte with pin k at bit 15-k, and `dev_wdata[7:0]` equals the holding register.
- R4: `dev_we` is 1 exactly during an even write. It is 0 during odd writes, reads, idle cycles and whenever the card is not selected.
- R5: During a selected read with `host_a_lo`=1, `host_d_out` pin k carries `dev_rdata[7-k]`.
- R6: During a selected read with `host_a_lo`=0, `host_d_out` pin k carries `dev_rdata[15-k]`.
- R7: `host_d_oe` is 1 exactly when the card is selected and `host_rd` is 1. With the card not selected, no host output is driven.
- R8: `even_en` is 1 exactly when the card is selected and `host_a_lo`=0. `lane_dir` equals `host_rd`, where 1 means the device drives toward the host.
- R9: The holding register keeps its value across every cycle that is not an odd write. This includes unselected cycles, even writes, reads, and cycles with `host_we_n`=1. The value shows up on the next even write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_sel_n | input | 1 | Card select, active low |
| host_a_lo | input | 1 | Low address line: 1 = odd (less significant) byte |
| host_rd | input | 1 | Read strobe, 1 = read cycle |
| host_we_n | input | 1 | Write pulse, active low |
| host_d_in | input | 8 | Host data in, pin 0 most significant |
| host_d_out | output | 8 | Host data out, pin 0 most significant |
| host_d_oe | output | 1 | Host data drive enable |
| even_en | output | 1 | Even-byte lane enable |
| lane_dir | output | 1 | Lane direction, 1 = toward host |
| dev_rdata | input | 16 | Device read word, bit 15 most significant |
| dev_wdata | output | 16 | Device write word |
| dev_we | output | 1 | Device word write strobe |

## Verification
The assertions assume that the host control lines are stable around each clock edge. They also assume that a write pulse is never active while the read strobe is high. The bench keeps to both assumptions by changing inputs only on the falling edge. Its random mix covers reads and writes under both selects and both byte lanes, but it never drives a low write pulse together with a high read strobe. Directed sequences pin down the reset value of the holding register and the odd-then-even word order.

// File: rtl/bmx_pkg.sv
// Package: shared widths and the host cycle classification.
// Assumes a host that moves each word as two equal-width byte cycles.
package bmx_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        CYC_IDLE    = 3'd0,
        CYC_ODD_WR  = 3'd1,
        CYC_EVEN_WR = 3'd2,
        CYC_ODD_RD  = 3'd3,
        CYC_EVEN_RD = 3'd4
    } cyc_e;
endpackage

// File: rtl/bmx_cycle_dec.sv
// Module: bmx_cycle_dec
// Classifies the current host cycle from select, low address, read strobe
// and write pulse. Purely combinational. Assumes the write pulse is
// ignored while the read strobe is high.
module bmx_cycle_dec
    import bmx_pkg::*;
(
    input  logic card_sel_n,
    input  logic host_a_lo,
    input  logic host_rd,
    input  logic host_we_n,
    output cyc_e cyc
);
    // Decode select, direction and lane into one cycle kind.
    always_comb begin
        cyc = CYC_IDLE;
        if (!card_sel_n) begin
            if (host_rd)
                cyc = host_a_lo ? CYC_ODD_RD : CYC_EVEN_RD;
            else if (!host_we_n)
                cyc = host_a_lo ? CYC_ODD_WR : CYC_EVEN_WR;
        end
    end
endmodule

// File: rtl/bmx_lane_rev.sv
// Module: bmx_lane_rev
// Reverses the bit order of one byte lane, mapping the host numbering
// (bit 0 most significant) to the device numbering (top bit most
// significant) or back. Assumes nothing; it is pure wiring.
module bmx_lane_rev #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = a[W-1-i];
    end
endmodule

// File: rtl/bmx_hold_reg.sv
// Module: bmx_hold_reg
// Holds the odd (less significant) write byte until the even cycle
// arrives. Loads only on an odd-write cycle and resets synchronously
// to zero. Assumes the input byte is already in device bit order.
module bmx_hold_reg
    import bmx_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cyc_e         cyc,
    input  logic [W-1:0] byte_in,
    output logic [W-1:0] hold_q
);
    // Capture the odd byte; keep it on every other cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (cyc == CYC_ODD_WR)
            hold_q <= byte_in;
    end

    AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_ODD_WR) |=> (hold_q == $past(byte_in))); // R2
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != CYC_ODD_WR) |=> $stable(hold_q)); // R9
endmodule

// File: rtl/bmx_bridge.sv
// Module: bmx_bridge (top)
// Rebuilds a 16-bit device path from a byte-multiplexed host bus with
// the odd byte first. Writes merge the held odd byte with the live even
// byte; reads steer one device half onto the host lane. Assumes inputs
// are synchronous to clk and that select is decoded outside.
module bmx_bridge
    import bmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_sel_n,
    input  logic              host_a_lo,
    input  logic              host_rd,
    input  logic              host_we_n,
    input  logic [BYTE_W-1:0] host_d_in,
    output logic [BYTE_W-1:0] host_d_out,
    output logic              host_d_oe,
    output logic              even_en,
    output logic              lane_dir,
    input  logic [WORD_W-1:0] dev_rdata,
    output logic [WORD_W-1:0] dev_wdata,
    output logic              dev_we
);
    cyc_e              cyc;
    logic [BYTE_W-1:0] din_dev;
    logic [BYTE_W-1:0] hold_q;
    logic [BYTE_W-1:0] rd_half;

    bmx_cycle_dec u_dec (
        .card_sel_n (card_sel_n),
        .host_a_lo  (host_a_lo),
        .host_rd    (host_rd),
        .host_we_n  (host_we_n),
        .cyc        (cyc)
    );

    bmx_lane_rev #(.W(BYTE_W)) u_rev_in (
        .a (host_d_in),
        .y (din_dev)
    );

    bmx_hold_reg #(.W(BYTE_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc     (cyc),
        .byte_in (din_dev),
        .hold_q  (hold_q)
    );

    // Pick the device half addressed by the low address line.
    always_comb begin
        rd_half = host_a_lo ? dev_rdata[BYTE_W-1:0] : dev_rdata[WORD_W-1:BYTE_W];
    end

    bmx_lane_rev #(.W(BYTE_W)) u_rev_out (
        .a (rd_half),
        .y (host_d_out)
    );

    // Lane controls and the device write strobe from the cycle kind.
    always_comb begin
        host_d_oe = (cyc == CYC_ODD_RD) || (cyc == CYC_EVEN_RD);
        dev_we    = (cyc == CYC_EVEN_WR);
        even_en   = !card_sel_n && !host_a_lo;
        lane_dir  = host_rd;
        dev_wdata = {din_dev, hold_q};
    end

    AST_WE_EVEN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        dev_we |-> (!host_a_lo && !card_sel_n)); // R4
    AST_WE_NOT_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        dev_we |-> !host_d_oe); // R7
    AST_LOW_HALF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        dev_we |-> (dev_wdata[BYTE_W-1:0] == hold_q)); // R3
    AST_QUIET_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
        card_sel_n |-> (!host_d_oe && !dev_we && !even_en)); // R7
endmodule

// File: tb/sim_bmx_bridge.sv
module sim_bmx_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        card_sel_n = 1'b1;
    logic        host_a_lo = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_we_n = 1'b1;
    logic [7:0]  host_d_in = 8'h00;
    logic [7:0]  host_d_out;
    logic        host_d_oe;
    logic        even_en;
    logic        lane_dir;
    logic [15:0] dev_rdata = 16'h0000;
    logic [15:0] dev_wdata;
    logic        dev_we;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] hold_m = 8'h00;

    always #4 clk = ~clk;

    bmx_bridge u0 (
        .clk(clk), .rst_n(rst_n), .card_sel_n(card_sel_n), .host_a_lo(host_a_lo),
        .host_rd(host_rd), .host_we_n(host_we_n), .host_d_in(host_d_in),
        .host_d_out(host_d_out), .host_d_oe(host_d_oe), .even_en(even_en),
        .lane_dir(lane_dir), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata), .dev_we(dev_we)
    );

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle after a falling edge, check outputs mid-cycle, update model.
    task automatic cycle(input logic sel_n, input logic alo, input logic rd,
                         input logic we_n, input logic [7:0] d, input logic [15:0] rdat);
        logic sel, ewr, owr;
        @(negedge clk);
        card_sel_n = sel_n; host_a_lo = alo; host_rd = rd; host_we_n = we_n;
        host_d_in = d; dev_rdata = rdat;
        #1;
        sel = !sel_n;
        ewr = sel && !alo && !rd && !we_n;
        owr = sel && alo && !rd && !we_n;
        chk("R7 oe", {15'd0, host_d_oe}, {15'd0, sel && rd});
        chk("R4 we", {15'd0, dev_we}, {15'd0, ewr});
        chk("R8 even_en", {15'd0, even_en}, {15'd0, sel && !alo});
        chk("R8 dir", {15'd0, lane_dir}, {15'd0, rd});
        if (sel && rd && alo) chk("R5 odd read", {8'd0, host_d_out}, {8'd0, rev8(rdat[7:0])});
        if (sel && rd && !alo) chk("R6 even read", {8'd0, host_d_out}, {8'd0, rev8(rdat[15:8])});
        if (ewr) chk("R3 R9 word", dev_wdata, {rev8(d), hold_m});
        @(posedge clk);
        if (owr) hold_m = rev8(d);
    endtask

    initial begin : watchdog
        #1000000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: first even write after reset carries zero low half
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 8'h5A, 16'h0);
        chk("R1 reset hold", {8'd0, dev_wdata[7:0]}, 16'h0000);
        // R2/R3: odd then even word write, bit reversal
        cycle(1'b0, 1'b1, 1'b0, 1'b0, 8'h01, 16'h0);
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 16'h0);
        chk("R2 R3 merge", dev_wdata, 16'h0180);
        // R9/R7: unselected odd write must not load
        cycle(1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 16'h0);
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0);
        chk("R9 unsel keep", {8'd0, dev_wdata[7:0]}, 16'h0080);
        // R9: odd cycle with write pulse high does not load
        cycle(1'b0, 1'b1, 1'b0, 1'b1, 8'h3C, 16'h0);
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0);
        chk("R9 idle keep", {8'd0, dev_wdata[7:0]}, 16'h0080);
        // R5/R6 directed
        cycle(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 16'h1234);
        chk("R5 odd read", {8'd0, host_d_out}, 16'h002C);
        cycle(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 16'h1234);
        chk("R6 even read", {8'd0, host_d_out}, 16'h0048);
        // Reset again mid-run: R1
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1; hold_m = 8'h00;
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 16'h0);
        chk("R1 reset again", {8'd0, dev_wdata[7:0]}, 16'h0000);
        // Random mix, never write pulse with read strobe
        for (int k = 0; k < 600; k++) begin
            logic s, a, r, w;
            s = ($urandom % 4) == 0;
            a = $urandom % 2;
            r = $urandom % 2;
            w = r ? 1'b1 : 1'($urandom % 2);
            cycle(s, a, r, w, 8'($urandom), 16'($urandom));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule